// File: doc/BRIEF.md
# Disk Command Block Issuer

This block sits on the host side of a fixed-disk controller. It accepts one read or write request at a time on a valid/ready port. A request carries a linear block number, a byte count, a device number and a direction. The block turns the request into the four-word command block the controller expects. A serial divider first maps the linear block number onto cylinder, head and sector, using the sectors-per-track and head count on the configuration pins.

Before any command word goes out, the block runs the attention handshake on the controller's register strobes:

1. Interrupts are switched off in the control register.
2. The block polls the controller's busy flag until it drops.
3. The attention byte is written.
4. Interrupts are switched back on.

The four command words are then written one at a time. After each word the block polls the command-register-full flag until the controller has taken that word. Both polling loops are bounded. The request ends with exactly one one-cycle indication: done, I/O error (the controller stayed busy) or device too slow (a word was never taken).

The request port is the only stream. `req_ready` is high only while the block is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. While a request is in progress the requester is held off, and anything shown on the request pins is ignored.

The controller side must raise the full flag by the cycle that follows a word strobe. It must keep the flag high until it has consumed the word. The block samples geometry and request fields only in the accepting cycle.

Top module: `disk_cmd_issuer`

## Requirements
- R1: `req_ready` is high only while idle. A request is accepted when `req_valid` and `req_ready` are both high. After acceptance `req_ready` stays low until the outcome pulse, and `req_valid` pulses seen during that time cause no writes and no outcome.
- R2: Every accepted request starts with a control-register write of 0x00. The attention byte follows, with the device number in bits 7:5 and attention code 0x01 in bits 4:0. Then comes a control-register write of 0x01 (interrupt enable), and only then the first command word.
- R3: If `stat_busy` is still high on POLL_MAX consecutive polls after the 0x00 control write, the block pulses `err_io`. In that case it writes no attention byte, no control 0x01 and no command word.
- R4: When `req_after_reset` is high at acceptance, the busy poll is skipped. The attention byte follows the 0x00 control write whatever the state of `stat_busy`.
- R5: Word 0 is {2'b01 (four-word type), 6'd2 (options), device[2:0], command code[4:0]}. The command code is 1 for a read (`req_write`=0) and 2 for a write.
- R6: Word 1 is the byte count divided by 512, truncated to 16 bits.
- R7: With track = block / sectors-per-track, sector = block mod sectors-per-track, head = track mod heads and cylinder = track / heads, word 2 is {cylinder[4:0], head[5:0], sector[4:0]}.
- R8: Word 3 carries cylinder bits 9:5 in its bits 4:0, with zeros above.
- R9: Words leave in index order 0, 1, 2, 3, each as one `cmd_we` cycle with the low byte on `cmd_data[7:0]`. A word is never written while `stat_cmd_full` is still high from the previous word.
- R10: If `stat_cmd_full` is still high on POLL_MAX consecutive polls after a word, the block pulses `err_slow` and writes no further word.
- R11: After word 3 has been taken, `done` pulses for one cycle and `req_ready` is high again. At most one of `done`, `err_io` and `err_slow` is high in any cycle.
- R12: Out of reset, `req_ready` is high and every strobe and outcome output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_lba | input | LBA_W | Linear block number |
| req_bytes | input | BYTES_W | Transfer length in bytes |
| req_dev | input | 3 | Device number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_after_reset | input | 1 | Skip the busy poll (acknowledging a reset) |
| cfg_spt | input | GEO_W | Sectors per track (non-zero) |
| cfg_heads | input | GEO_W | Heads per cylinder (non-zero) |
| ctl_we | output | 1 | Control register write strobe |
| ctl_data | output | 8 | Control register value |
| att_we | output | 1 | Attention register write strobe |
| att_data | output | 8 | Attention byte |
| cmd_we | output | 1 | Command word write strobe |
| cmd_data | output | 16 | Command word, low byte in bits 7:0 |
| stat_busy | input | 1 | Controller busy flag |
| stat_cmd_full | input | 1 | Command register full flag |
| done | output | 1 | Command block handed off |
| err_io | output | 1 | Busy poll expired |
| err_slow | output | 1 | Full-flag poll expired |

## Verification
The bench drives geometries where the cylinder needs more than ten bits. A design that split the cylinder across words 2 and 3 at the wrong bit, or dropped the truncation, would show wrong words on the scoreboard.

It holds the busy flag high with and without the reset-acknowledge option. A design that ignored the option would report an I/O error instead of handing off the words. A design that skipped the poll would write the attention byte while the controller is busy.

A full flag that is slow or never clears tests the per-word handshake. A block that wrote ahead, or failed to give up, would either write into a full register or hang.

Extra request pulses during a busy command test the hold-off. A design that took them would issue a second, unexpected command block.

// File: rtl/cbi_pkg.sv
`timescale 1ns/1ps
package cbi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GEOM,
    ST_CTL_OFF,
    ST_BUSY,
    ST_ATTN,
    ST_CTL_ON,
    ST_WORD,
    ST_WAIT
  } issue_state_t;

  localparam logic [7:0] CTL_IRQ_OFF = 8'h00;
  localparam logic [7:0] CTL_IRQ_ON  = 8'h01;
  localparam logic [4:0] ATT_CMD_REQ = 5'h01;
  localparam logic [4:0] OP_READ     = 5'd1;
  localparam logic [4:0] OP_WRITE    = 5'd2;
  localparam logic [5:0] OPT_RW      = 6'd2;
  localparam logic [1:0] TYPE_LONG   = 2'b01;
  localparam int         CYL_W       = 10;
  localparam int         HEAD_W      = 6;
  localparam int         SECT_W      = 5;
  localparam int         NWORDS      = 4;

endpackage

// File: rtl/cbi_divider.sv
`timescale 1ns/1ps
module cbi_divider #(
  parameter int N = 24,
  parameter int D = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N-1:0] dividend_i,
  input  logic [D-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] quot_o,
  output logic [D-1:0] rem_o
);
  localparam int CNT_W = $clog2(N + 1);

  logic [N-1:0] q_r;
  logic [D-1:0] r_r;
  logic [D-1:0] d_r;
  logic [CNT_W-1:0] cnt_r;
  logic [D:0] trial, diff;
  logic ge;

  assign trial = {r_r, q_r[N-1]};
  assign ge    = trial >= {1'b0, d_r};
  assign diff  = trial - {1'b0, d_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      cnt_r  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        q_r    <= dividend_i;
        r_r    <= '0;
        d_r    <= divisor_i;
        cnt_r  <= CNT_W'(N);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        q_r   <= {q_r[N-2:0], ge};
        r_r   <= ge ? diff[D-1:0] : trial[D-1:0];
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = q_r;
  assign rem_o  = r_r;

  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

endmodule

// File: rtl/cbi_chs.sv
`timescale 1ns/1ps
module cbi_chs
  import cbi_pkg::*;
#(
  parameter int LBA_W = 24,
  parameter int GEO_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [GEO_W-1:0]  spt_i,
  input  logic [GEO_W-1:0]  heads_i,
  output logic              done_o,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [SECT_W-1:0] sect_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_TRACK, PH_CYL} phase_t;

  phase_t             phase;
  logic [GEO_W-1:0]   heads_r;
  logic               div_start, div_busy, div_done;
  logic [LBA_W-1:0]   div_a, div_q;
  logic [GEO_W-1:0]   div_b, div_r;

  always_comb begin
    div_start = 1'b0;
    div_a     = lba_i;
    div_b     = spt_i;
    if (start_i) begin
      div_start = 1'b1;
    end else if (phase == PH_TRACK && div_done) begin
      div_start = 1'b1;
      div_a     = div_q;
      div_b     = heads_r;
    end
  end

  cbi_divider #(.N(LBA_W), .D(GEO_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (div_start),
    .dividend_i(div_a),
    .divisor_i (div_b),
    .busy_o    (div_busy),
    .done_o    (div_done),
    .quot_o    (div_q),
    .rem_o     (div_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      heads_r <= '0;
      cyl_o   <= '0;
      head_o  <= '0;
      sect_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase)
        PH_IDLE: if (start_i) begin
          heads_r <= heads_i;
          phase   <= PH_TRACK;
        end
        PH_TRACK: if (div_done) begin
          sect_o <= div_r[SECT_W-1:0];
          phase  <= PH_CYL;
        end
        PH_CYL: if (div_done) begin
          head_o <= div_r;
          cyl_o  <= div_q[CYL_W-1:0];
          done_o <= 1'b1;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !div_busy) |=> div_busy);

endmodule

// File: rtl/cbi_words.sv
`timescale 1ns/1ps
module cbi_words
  import cbi_pkg::*;
(
  input  logic [1:0]        idx_i,
  input  logic [2:0]        dev_i,
  input  logic              write_i,
  input  logic [15:0]       blocks_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [15:0]       word_o
);
  logic [4:0] op;
  assign op = write_i ? OP_WRITE : OP_READ;

  always_comb begin
    case (idx_i)
      2'd0:    word_o = {TYPE_LONG, OPT_RW, dev_i, op};
      2'd1:    word_o = blocks_i;
      2'd2:    word_o = {cyl_i[4:0], head_i, sect_i};
      default: word_o = {11'd0, cyl_i[9:5]};
    endcase
  end

endmodule

// File: rtl/disk_cmd_issuer.sv
`timescale 1ns/1ps
module disk_cmd_issuer
  import cbi_pkg::*;
#(
  parameter int LBA_W    = 24,
  parameter int BYTES_W  = 25,
  parameter int GEO_W    = 6,
  parameter int POLL_MAX = 10000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LBA_W-1:0]   req_lba,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic [2:0]         req_dev,
  input  logic               req_write,
  input  logic               req_after_reset,
  input  logic [GEO_W-1:0]   cfg_spt,
  input  logic [GEO_W-1:0]   cfg_heads,
  output logic               ctl_we,
  output logic [7:0]         ctl_data,
  output logic               att_we,
  output logic [7:0]         att_data,
  output logic               cmd_we,
  output logic [15:0]        cmd_data,
  input  logic               stat_busy,
  input  logic               stat_cmd_full,
  output logic               done,
  output logic               err_io,
  output logic               err_slow
);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [1:0] LAST_IDX = 2'(NWORDS - 1);

  issue_state_t      state;
  logic [2:0]        dev_q;
  logic              wr_q, aft_q;
  logic [15:0]       blk_q;
  logic [1:0]        word_idx;
  logic [POLL_W-1:0] poll_cnt;
  logic              poll_last;
  logic              accept;
  logic              geo_done;
  logic [CYL_W-1:0]  cyl;
  logic [HEAD_W-1:0] head;
  logic [SECT_W-1:0] sect;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign poll_last = (poll_cnt == POLL_W'(POLL_MAX - 1));

  cbi_chs #(.LBA_W(LBA_W), .GEO_W(GEO_W)) u_chs (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(accept),
    .lba_i  (req_lba),
    .spt_i  (cfg_spt),
    .heads_i(cfg_heads),
    .done_o (geo_done),
    .cyl_o  (cyl),
    .head_o (head),
    .sect_o (sect)
  );

  cbi_words u_words (
    .idx_i   (word_idx),
    .dev_i   (dev_q),
    .write_i (wr_q),
    .blocks_i(blk_q),
    .cyl_i   (cyl),
    .head_i  (head),
    .sect_i  (sect),
    .word_o  (cmd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dev_q    <= '0;
      wr_q     <= 1'b0;
      aft_q    <= 1'b0;
      blk_q    <= '0;
      word_idx <= '0;
      poll_cnt <= '0;
      done     <= 1'b0;
      err_io   <= 1'b0;
      err_slow <= 1'b0;
    end else begin
      done     <= 1'b0;
      err_io   <= 1'b0;
      err_slow <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          dev_q <= req_dev;
          wr_q  <= req_write;
          aft_q <= req_after_reset;
          blk_q <= 16'(req_bytes >> 9);
          state <= ST_GEOM;
        end
        ST_GEOM: if (geo_done) state <= ST_CTL_OFF;
        ST_CTL_OFF: begin
          poll_cnt <= '0;
          state    <= aft_q ? ST_ATTN : ST_BUSY;
        end
        ST_BUSY: begin
          if (!stat_busy) begin
            state <= ST_ATTN;
          end else if (poll_last) begin
            err_io <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_ATTN: state <= ST_CTL_ON;
        ST_CTL_ON: begin
          word_idx <= '0;
          state    <= ST_WORD;
        end
        ST_WORD: begin
          poll_cnt <= '0;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!stat_cmd_full) begin
            if (word_idx == LAST_IDX) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              word_idx <= word_idx + 1'b1;
              state    <= ST_WORD;
            end
          end else if (poll_last) begin
            err_slow <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ctl_we   = (state == ST_CTL_OFF) || (state == ST_CTL_ON);
  assign ctl_data = (state == ST_CTL_ON) ? CTL_IRQ_ON : CTL_IRQ_OFF;
  assign att_we   = (state == ST_ATTN);
  assign att_data = {dev_q, ATT_CMD_REQ};
  assign cmd_we   = (state == ST_WORD);

  // R1
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R2
  attn_then_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    att_we |=> (ctl_we && ctl_data == CTL_IRQ_ON));

  // R2
  first_word_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && word_idx == 2'd0) |-> ($past(ctl_we) && $past(ctl_data) == CTL_IRQ_ON));

  // R5
  word0_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && word_idx == 2'd0) |-> (cmd_data[15:14] == TYPE_LONG));

  // R9
  word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> !cmd_we);

  // R10
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= POLL_W'(POLL_MAX - 1));

  // R11
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_io, err_slow}));

endmodule

// File: tb/test_disk_cmd_issuer.sv
`timescale 1ns/1ps
module test_disk_cmd_issuer;
  localparam int LBA_W = 24;
  localparam int BYTES_W = 25;
  localparam int GEO_W = 6;
  localparam int POLL_MAX = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LBA_W-1:0] req_lba = '0;
  logic [BYTES_W-1:0] req_bytes = '0;
  logic [2:0] req_dev = '0;
  logic req_write = 1'b0;
  logic req_after_reset = 1'b0;
  logic [GEO_W-1:0] cfg_spt = 6'd17;
  logic [GEO_W-1:0] cfg_heads = 6'd8;
  logic ctl_we, att_we, cmd_we;
  logic [7:0] ctl_data, att_data;
  logic [15:0] cmd_data;
  logic stat_busy, stat_cmd_full;
  logic done, err_io, err_slow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_until = 0;
  logic busy_stuck = 1'b0;
  logic full_stuck = 1'b0;
  int full_lat = 0;
  logic full_r = 1'b0;
  int lat_cnt = 0;

  logic [17:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  disk_cmd_issuer #(.LBA_W(LBA_W), .BYTES_W(BYTES_W), .GEO_W(GEO_W), .POLL_MAX(POLL_MAX)) i_disk_cmd_issuer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lba(req_lba), .req_bytes(req_bytes), .req_dev(req_dev), .req_write(req_write),
    .req_after_reset(req_after_reset), .cfg_spt(cfg_spt), .cfg_heads(cfg_heads),
    .ctl_we(ctl_we), .ctl_data(ctl_data), .att_we(att_we), .att_data(att_data),
    .cmd_we(cmd_we), .cmd_data(cmd_data), .stat_busy(stat_busy),
    .stat_cmd_full(stat_cmd_full), .done(done), .err_io(err_io), .err_slow(err_slow)
  );

  assign stat_busy = busy_stuck || (cyc < busy_until);
  assign stat_cmd_full = full_r;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_we) begin
      full_r  <= 1'b1;
      lat_cnt <= full_lat;
    end else if (full_r) begin
      if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
      else if (!full_stuck) full_r <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input logic [1:0] kind, input logic [15:0] data, input string req);
    exp_q.push_back({kind, data});
    tag_q.push_back(req);
  endtask

  task automatic observe(input logic [1:0] kind, input logic [15:0] data);
    logic [17:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1", "unexpected activity", {kind, data}, 0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e == {kind, data}, t, "scoreboard item", {kind, data}, e);
    end
  endtask

  // monitor: kinds 0 control, 1 attention, 2 command word, 3 outcome (0 done,1 io,2 slow)
  always @(negedge clk) begin
    if (rst_n) begin
      if (ctl_we) observe(2'd0, {8'd0, ctl_data});
      if (att_we) observe(2'd1, {8'd0, att_data});
      if (cmd_we) begin
        check(!full_r, "R9", "word written while full", 1, 0);
        observe(2'd2, cmd_data);
      end
      if (done) observe(2'd3, 16'd0);
      if (err_io) observe(2'd3, 16'd1);
      if (err_slow) observe(2'd3, 16'd2);
    end
  end

  // outcome: 0 done, 1 busy poll expiry, 2 full poll expiry
  task automatic issue(input int lba, input int bytes, input logic [2:0] dev,
                       input logic wr, input logic aft, input int spt, input int hds,
                       input int outcome, input bit poke);
    longint track, sec, head, cyl;
    logic [4:0] op;
    track = lba / spt;
    sec   = lba % spt;
    head  = track % hds;
    cyl   = track / hds;
    op    = wr ? 5'd2 : 5'd1;
    expect_item(2'd0, 16'h0000, "R2");
    if (outcome == 1) begin
      expect_item(2'd3, 16'd1, "R3");
    end else begin
      expect_item(2'd1, {8'd0, dev, 5'h01}, aft ? "R4" : "R2");
      expect_item(2'd0, 16'h0001, "R2");
      expect_item(2'd2, {2'b01, 6'd2, dev, op}, "R5");
      if (outcome == 2) begin
        expect_item(2'd3, 16'd2, "R10");
      end else begin
        expect_item(2'd2, 16'((bytes / 512) & 16'hffff), "R6");
        expect_item(2'd2, {5'(cyl & 31), 6'(head), 5'(sec)}, "R7");
        expect_item(2'd2, {11'd0, 5'((cyl >> 5) & 31)}, "R8");
        expect_item(2'd3, 16'd0, "R11");
      end
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
    req_lba = LBA_W'(lba);
    req_bytes = BYTES_W'(bytes);
    req_dev = dev;
    req_write = wr;
    req_after_reset = aft;
    cfg_spt = GEO_W'(spt);
    cfg_heads = GEO_W'(hds);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      check(req_ready == 1'b0, "R1", "ready while in progress", req_ready, 0);
      req_lba = 24'h00abcd;
      req_dev = 3'd6;
      req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    for (int i = 0; i < 30000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R11", "items left unseen", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready after outcome", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R12", "ready after reset", req_ready, 1);
    check({ctl_we, att_we, cmd_we, done, err_io, err_slow} == 6'b0, "R12",
          "strobes after reset", {ctl_we, att_we, cmd_we, done, err_io, err_slow}, 0);

    issue(0, 512, 3'd0, 1'b0, 1'b0, 17, 8, 0, 1'b0);
    issue(12345, 4096, 3'd1, 1'b1, 1'b0, 32, 16, 0, 1'b0);
    issue(600000, 131072, 3'd5, 1'b0, 1'b0, 31, 15, 0, 1'b0);
    full_lat = 5;
    issue(777777, 1000, 3'd2, 1'b1, 1'b0, 17, 4, 0, 1'b0);
    full_lat = 0;
    busy_until = cyc + 60;
    issue(4242, 33554431, 3'd7, 1'b0, 1'b0, 63, 63, 0, 1'b1);
    busy_stuck = 1'b1;
    issue(100, 512, 3'd3, 1'b0, 1'b0, 17, 8, 1, 1'b0);
    issue(100, 512, 3'd3, 1'b1, 1'b1, 17, 8, 0, 1'b0);
    busy_stuck = 1'b0;
    full_stuck = 1'b1;
    issue(55, 1024, 3'd4, 1'b1, 1'b0, 17, 8, 2, 1'b0);
    full_stuck = 1'b0;
    repeat (4) @(negedge clk);
    check(full_r == 1'b0, "R10", "no word after slow timeout", full_r, 0);
    issue(16777215, 512, 3'd1, 1'b0, 1'b0, 1, 1, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 5);
    errors++;
    $display("FAIL watchdog R11: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule